// File: doc/BRIEF.md
# Carry-Speculating Variable-Latency Adder

This block is a ripple-carry adder whose carry chain is broken at one or more internal bit positions. At each break, the carry into that bit is not taken from the ripple below. It is replaced by a cheap guess: either the generate term of the bit just below the break, or the constant zero. Because the guessed carries arrive early, the longest combinational path from the operand register to the sum is one ripple segment rather than the whole word. Most additions therefore complete in the cycle after the operands are accepted.

A second, exact carry network computes the true carry at every break. If any guess disagrees with its true carry, a single mismatch flag is raised and the result is withheld. The true carries are captured in flip-flops, and the mismatch is captured too. On the following cycle, the captured flag steers every break multiplexer to its stored true carry, and the corrected sum is delivered. The slow case is therefore a genuine two-cycle sequential path, not a multi-cycle combinational one.

Operands arrive over a valid/ready handshake. While a correction is pending, the block drops ready so that the held operands stay in place. The word width, the break positions and the kind of guess at each break are parameters.

Top module: `cvs_adder`

## Requirements
- R1: During and directly after reset, out_valid, out_busy and out_miss are 0 and in_ready is 1.
- R2: An operation is accepted on a rising clock edge where in_valid and in_ready are both 1. In the next cycle exactly one of two things holds: either out_valid is 1 with out_miss 0, or out_busy is 1.
- R3: When every break guess equals its true carry, the cycle after acceptance shows out_valid=1, out_miss=0 and {out_cout,out_sum} equal to in_a+in_b+in_cin.
- R4: When at least one break guess differs from its true carry, the cycle after acceptance shows out_busy=1 and out_valid=0.
- R5: The cycle after an out_busy cycle shows out_valid=1, out_miss=1 and the exact {out_cout,out_sum} of the held operation.
- R6: in_ready is 0 in every out_busy cycle. Operands presented in that cycle are not taken, and the pending result is unchanged.
- R7: A break at position p with the generate guess predicts carry-into-bit-p as in_a[p-1]&in_b[p-1]. A break with the zero guess predicts 0. A misprediction happens exactly when that prediction differs from bit p of (in_a mod 2^p)+(in_b mod 2^p)+in_cin.
- R8: However many breaks mispredict for one operation, the operation costs exactly one out_busy cycle and one out_miss cycle.
- R9: For uniformly random operands, the number of out_miss results equals the number of operations that mispredict under R7.
- R10: With in_valid held high and no mispredictions, one operation is accepted and one result is delivered on every cycle.
- R11: out_cout is the carry out of the most significant bit of the exact sum, on both the one-cycle and the two-cycle path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands on in_a, in_b, in_cin are offered |
| in_ready | output | 1 | Block can take operands this cycle |
| in_a | input | WIDTH | First addend |
| in_b | input | WIDTH | Second addend |
| in_cin | input | 1 | Carry into bit 0 |
| out_valid | output | 1 | out_sum and out_cout hold a correct result |
| out_sum | output | WIDTH | Sum bits |
| out_cout | output | 1 | Carry out of the top bit |
| out_busy | output | 1 | A misprediction was found; result withheld this cycle |
| out_miss | output | 1 | The result shown took the two-cycle correction path |

## Verification
The bound checker watches the timing skeleton on every cycle. It checks that a busy cycle blocks input and withholds the result, that a busy cycle is always followed by a corrected result flagged as a miss, and that misses never come two in a row. It also checks that any valid result equals the sum of the last accepted operands, and that every acceptance is answered in the next cycle. Which operand patterns must mispredict, and whether a given guess kind is implemented as specified, can only be shown by the bench. The bench drives directed carry patterns at each break, operations that mispredict at several breaks at once, input offered during a hold, back-to-back bursts, and a random run whose miss count is compared against an independent prediction.

// File: rtl/cvs_pkg.sv
package cvs_pkg;

    // Kind of guess placed at a carry break
    typedef enum logic {
        APX_ZERO = 1'b0,   // carry guessed as constant 0
        APX_GEN  = 1'b1    // carry guessed as generate of the bit below
    } apx_mode_e;

    localparam int unsigned POS_BITS = 8;  // width of one break-position field

    function automatic logic maj3(logic x, logic y, logic z);
        return (x & y) | (x & z) | (y & z);
    endfunction

endpackage

// File: rtl/cvs_exact_chain.sv
// Full ripple from bit 0 up to the highest break; yields true carries at breaks.
module cvs_exact_chain
    import cvs_pkg::*;
#(
    parameter int unsigned SPAN     = 11,
    parameter int unsigned NCUT     = 2,
    parameter logic [NCUT*POS_BITS-1:0] CUT_POS = {8'd11, 8'd5}
) (
    input  logic [SPAN-1:0] a,
    input  logic [SPAN-1:0] b,
    input  logic            cin,
    output logic [NCUT-1:0] cut_carry
);

    logic [SPAN:0] c;

    assign c[0] = cin;

    for (genvar i = 0; i < SPAN; i++) begin : g_rip
        assign c[i+1] = maj3(a[i], b[i], c[i]);
    end

    for (genvar k = 0; k < NCUT; k++) begin : g_tap
        localparam int unsigned P = int'(CUT_POS[k*POS_BITS +: POS_BITS]);
        assign cut_carry[k] = c[P];
    end

endmodule

// File: rtl/cvs_spec_chain.sv
// Segmented ripple: at each break the carry comes from a guess or a stored value.
module cvs_spec_chain
    import cvs_pkg::*;
#(
    parameter int unsigned WIDTH    = 16,
    parameter int unsigned NCUT     = 2,
    parameter logic [NCUT*POS_BITS-1:0] CUT_POS = {8'd11, 8'd5},
    parameter logic [NCUT-1:0]          APPROX_GEN = 2'b01
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    input  logic             use_exact,
    input  logic [NCUT-1:0]  exact_cut,
    output logic [NCUT-1:0]  approx,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);

    // Index of the break that sits on carry position pos, or -1
    function automatic int cut_of(int pos);
        int r;
        r = -1;
        for (int k = 0; k < int'(NCUT); k++) begin
            if (int'(CUT_POS[k*POS_BITS +: POS_BITS]) == pos) r = k;
        end
        return r;
    endfunction

    logic [WIDTH:0] c;

    assign c[0] = cin;

    for (genvar k = 0; k < NCUT; k++) begin : g_apx
        localparam int unsigned P = int'(CUT_POS[k*POS_BITS +: POS_BITS]);
        if (apx_mode_e'(APPROX_GEN[k]) == APX_GEN) begin : g_gen
            assign approx[k] = a[P-1] & b[P-1];
        end else begin : g_zero
            assign approx[k] = 1'b0;
        end
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        localparam int K = cut_of(i + 1);
        assign sum[i] = a[i] ^ b[i] ^ c[i];
        if (K >= 0) begin : g_brk
            assign c[i+1] = use_exact ? exact_cut[K] : approx[K];
        end else begin : g_rip
            assign c[i+1] = maj3(a[i], b[i], c[i]);
        end
    end

    assign cout = c[WIDTH];

endmodule

// File: rtl/cvs_err_detect.sv
// Per-break equality, combined by an AND tree, then inverted.
module cvs_err_detect #(
    parameter int unsigned NCUT = 2
) (
    input  logic [NCUT-1:0] exact_cut,
    input  logic [NCUT-1:0] approx,
    output logic            mismatch
);

    logic [NCUT-1:0] same;

    for (genvar k = 0; k < NCUT; k++) begin : g_eq
        assign same[k] = exact_cut[k] ~^ approx[k];
    end

    assign mismatch = ~(&same);

endmodule

// File: rtl/cvs_adder.sv
module cvs_adder
    import cvs_pkg::*;
#(
    parameter int unsigned WIDTH    = 16,
    parameter int unsigned NCUT     = 2,
    parameter logic [NCUT*POS_BITS-1:0] CUT_POS = {8'd11, 8'd5},
    parameter logic [NCUT-1:0]          APPROX_GEN = 2'b01
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    input  logic             in_cin,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_sum,
    output logic             out_cout,
    output logic             out_busy,
    output logic             out_miss
);

    // Break positions must rise; the last one bounds the exact chain
    localparam int unsigned LAST_POS =
        int'(CUT_POS[(NCUT-1)*POS_BITS +: POS_BITS]);

    typedef struct packed {
        logic             op_valid;
        logic [WIDTH-1:0] a;
        logic [WIDTH-1:0] b;
        logic             cin;
        logic             recover;
        logic [NCUT-1:0]  exact;
    } state_t;

    state_t st_d, st_q;

    logic [NCUT-1:0] ex_cut;
    logic [NCUT-1:0] apx;
    logic            mismatch;
    logic            hold;
    logic            accept;

    cvs_exact_chain #(
        .SPAN    (LAST_POS),
        .NCUT    (NCUT),
        .CUT_POS (CUT_POS)
    ) u_exact (
        .a         (st_q.a[LAST_POS-1:0]),
        .b         (st_q.b[LAST_POS-1:0]),
        .cin       (st_q.cin),
        .cut_carry (ex_cut)
    );

    cvs_spec_chain #(
        .WIDTH      (WIDTH),
        .NCUT       (NCUT),
        .CUT_POS    (CUT_POS),
        .APPROX_GEN (APPROX_GEN)
    ) u_spec (
        .a         (st_q.a),
        .b         (st_q.b),
        .cin       (st_q.cin),
        .use_exact (st_q.recover),
        .exact_cut (st_q.exact),
        .approx    (apx),
        .sum       (out_sum),
        .cout      (out_cout)
    );

    cvs_err_detect #(
        .NCUT (NCUT)
    ) u_err (
        .exact_cut (ex_cut),
        .approx    (apx),
        .mismatch  (mismatch)
    );

    // A fresh operation with a bad guess holds the word for one more cycle
    assign hold     = st_q.op_valid & ~st_q.recover & mismatch;
    assign accept   = in_valid & ~hold;
    assign in_ready = ~hold;

    always_comb begin
        st_d         = st_q;
        st_d.recover = hold;
        if (hold) begin
            st_d.exact = ex_cut;
        end
        if (accept) begin
            st_d.op_valid = 1'b1;
            st_d.a        = in_a;
            st_d.b        = in_b;
            st_d.cin      = in_cin;
        end else if (!hold) begin
            st_d.op_valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.op_valid & (st_q.recover | ~mismatch);
    assign out_busy  = hold;
    assign out_miss  = st_q.op_valid & st_q.recover;

endmodule

// File: rtl/cvs_adder_chk.sv
module cvs_adder_chk #(
    parameter int unsigned WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [WIDTH-1:0] in_a,
    input logic [WIDTH-1:0] in_b,
    input logic             in_cin,
    input logic             out_valid,
    input logic [WIDTH-1:0] out_sum,
    input logic             out_cout,
    input logic             out_busy,
    input logic             out_miss
);

    logic [WIDTH:0] want_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            want_q <= '0;
        end else if (in_valid && in_ready) begin
            want_q <= {1'b0, in_a} + {1'b0, in_b} + {{WIDTH{1'b0}}, in_cin};
        end
    end

    AST_HOLD_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        out_busy |-> !in_ready);                                        // R6
    AST_HOLD_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        out_busy |-> !out_valid);                                       // R4
    AST_RECOVERY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        out_busy |=> (out_valid && out_miss));                          // R5
    AST_MISS_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_miss |-> $past(out_busy));                                  // R5
    AST_SINGLE_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
        out_miss |=> !out_miss);                                        // R8
    AST_ACCEPT_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> ((out_valid && !out_miss) || out_busy)); // R2
    AST_SUM_CORRECT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ({out_cout, out_sum} == want_q));                 // R3

endmodule

bind cvs_adder cvs_adder_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/cvs_adder_bench.sv
module cvs_adder_bench;

    localparam int W = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic          in_ready;
    logic [W-1:0]  in_a;
    logic [W-1:0]  in_b;
    logic          in_cin;
    logic          out_valid;
    logic [W-1:0]  out_sum;
    logic          out_cout;
    logic          out_busy;
    logic          out_miss;

    always #10 clk = ~clk;

    cvs_adder #(
        .WIDTH      (W),
        .NCUT       (2),
        .CUT_POS    ({8'd11, 8'd5}),
        .APPROX_GEN (2'b01)
    ) u_cvs_adder (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_a      (in_a),
        .in_b      (in_b),
        .in_cin    (in_cin),
        .out_valid (out_valid),
        .out_sum   (out_sum),
        .out_cout  (out_cout),
        .out_busy  (out_busy),
        .out_miss  (out_miss)
    );

    // Break 0 at carry position 5 guessed by generate; break 1 at 11 guessed zero
    int cutp [2] = '{5, 11};
    bit cgen [2] = '{1'b1, 1'b0};

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Reference state
    bit           m_valid = 1'b0;
    bit           m_rec   = 1'b0;
    logic [W-1:0] m_a     = '0;
    logic [W-1:0] m_b     = '0;
    logic         m_cin   = 1'b0;

    int dut_miss = 0, dut_busy = 0, dut_valid = 0, ref_miss = 0;

    function automatic bit predict_miss(logic [W-1:0] a, logic [W-1:0] b, logic cin);
        bit r;
        r = 1'b0;
        for (int k = 0; k < 2; k++) begin
            int p;
            logic [W:0] mask, s;
            logic ex, ap;
            p    = cutp[k];
            mask = (17'd1 << p) - 17'd1;
            s    = ({1'b0, a} & mask) + ({1'b0, b} & mask) + {16'd0, cin};
            ex   = s[p];
            ap   = cgen[k] ? (a[p-1] & b[p-1]) : 1'b0;
            if (ex !== ap) r = 1'b1;
        end
        return r;
    endfunction

    task automatic check(string tag, string what, longint act, longint exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One clock: compare outputs, drive inputs, advance the reference
    task automatic step(bit v, logic [W-1:0] a, logic [W-1:0] b, logic c, output bit acc);
        bit pm, e_busy, e_valid, e_miss, e_ready;
        string tag;
        logic [W:0] e_sum;
        @(negedge clk);
        pm      = m_valid && !m_rec && predict_miss(m_a, m_b, m_cin);
        e_busy  = pm;
        e_valid = m_valid && (m_rec || !pm);
        e_miss  = m_valid && m_rec;
        e_ready = !e_busy;
        tag = !m_valid ? "R2" : (m_rec ? "R5" : (pm ? "R4" : "R3"));
        check(tag, "out_valid", out_valid, e_valid);
        check(tag, "out_busy", out_busy, e_busy);
        check(tag, "out_miss", out_miss, e_miss);
        check(e_busy ? "R6" : tag, "in_ready", in_ready, e_ready);
        if (e_valid) begin
            e_sum = {1'b0, m_a} + {1'b0, m_b} + {16'd0, m_cin};
            check(tag, "out_sum", out_sum, e_sum[W-1:0]);
            check("R11", "out_cout", out_cout, e_sum[W]);
        end
        dut_miss  += int'(out_miss);
        dut_busy  += int'(out_busy);
        dut_valid += int'(out_valid);
        ref_miss  += int'(e_miss);
        in_valid = v;
        in_a     = a;
        in_b     = b;
        in_cin   = c;
        acc      = v && e_ready;
        @(posedge clk);
        if (e_busy) begin
            m_rec = 1'b1;
        end else if (acc) begin
            m_valid = 1'b1;
            m_rec   = 1'b0;
            m_a     = a;
            m_b     = b;
            m_cin   = c;
        end else begin
            m_valid = 1'b0;
            m_rec   = 1'b0;
        end
    endtask

    task automatic send(logic [W-1:0] a, logic [W-1:0] b, logic c);
        bit acc;
        do step(1'b1, a, b, c, acc); while (!acc);
    endtask

    task automatic idle(int n);
        bit acc;
        for (int i = 0; i < n; i++) step(1'b0, '0, '0, 1'b0, acc);
    endtask

    initial begin
        bit acc;
        int m0, b0, acc_cnt, v0;
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_a     = '0;
        in_b     = '0;
        in_cin   = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "out_valid in reset", out_valid, 0);
        check("R1", "in_ready in reset", in_ready, 1);
        check("R1", "out_busy in reset", out_busy, 0);
        check("R1", "out_miss in reset", out_miss, 0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1", "out_valid after reset", out_valid, 0);
        check("R1", "in_ready after reset", in_ready, 1);

        // R7: directed patterns at each break
        m0 = dut_miss;
        send(16'h0010, 16'h0010, 1'b0);   // generate at bit 4 is the true carry: hit
        idle(2);
        send(16'h0001, 16'h001F, 1'b0);   // carry ripples into bit 5, g4=0: miss
        idle(3);
        send(16'h0400, 16'h0400, 1'b0);   // carry into 11 is 1, guess 0: miss
        idle(3);
        send(16'h0000, 16'h0000, 1'b1);   // no carries: hit
        idle(2);
        check("R7", "directed miss count", dut_miss - m0, 2);

        // R8: both breaks wrong at once costs one hold and one correction
        m0 = dut_miss;
        b0 = dut_busy;
        send(16'h0401, 16'h041F, 1'b0);
        idle(3);
        check("R8", "hold cycles", dut_busy - b0, 1);
        check("R8", "miss results", dut_miss - m0, 1);

        // R6: operands offered during the hold are not taken
        step(1'b1, 16'h0001, 16'h001F, 1'b0, acc);
        check("R2", "accept miss op", acc, 1);
        step(1'b1, 16'h1234, 16'h0101, 1'b0, acc);
        check("R6", "accept during hold", acc, 0);
        step(1'b1, 16'h1234, 16'h0101, 1'b0, acc);
        check("R6", "accept in recovery", acc, 1);
        idle(3);

        // R10: back-to-back hits
        acc_cnt = 0;
        v0 = dut_valid;
        for (int i = 0; i < 20; i++) begin
            step(1'b1, 16'(i), 16'h0000, 1'b0, acc);
            acc_cnt += int'(acc);
        end
        idle(2);
        check("R10", "burst accepts", acc_cnt, 20);
        check("R10", "burst results", dut_valid - v0, 20);

        // R9: random traffic with gaps and full-width carries
        m0 = dut_miss;
        b0 = ref_miss;
        for (int i = 0; i < 1500; i++) begin
            if ($urandom_range(3) == 0) idle(1);
            send(16'($urandom), 16'($urandom), 1'($urandom));
        end
        send(16'hFFFF, 16'h0000, 1'b1);   // R11: carry out through both breaks
        send(16'hFFFF, 16'hFFFF, 1'b1);
        idle(4);
        check("R9", "random miss count", dut_miss - m0, ref_miss - b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule